// File: doc/BRIEF.md
# Serial DMA request encoder

This block reports the state of eight legacy DMA request inputs to a bus arbiter over one active-low wire, clocked by the PCI clock. When a request appears while the wire is idle, the encoder drives the wire low for one clock as a start marker. It then sends a frame of eight clock-wide slots, one for each channel. After the frame it holds the wire low for as long as the same set of requests stays pending.

The set of requests is captured into a shadow register at the start marker, so a frame always describes one consistent snapshot. If the pending set differs from that snapshot when the frame ends, or at any point while the wire is held, the wire goes high for one clock and a fresh marker and frame follow. One channel (channel 4 by default, chosen by a parameter mask) is never reported. Its slot always carries a low level, and its input takes no part in starting, holding or re-sending a frame.

Top module: `dreq_serial_enc`

## Requirements
- R1: With the wire idle (high) and at least one unmasked request sampled high at a clock edge, the wire is low for exactly the following clock period (start marker); the data slots begin in the period after it.
- R2: The eight periods after the marker carry channels 0 to 7 in ascending order, one per period; a pending channel is sent low and an idle channel high.
- R3: The slot of a masked channel (channel 4 by default) is always low, and a request on that channel alone never starts a frame, holds the wire or causes a re-send.
- R4: After the last slot, the wire stays low for as long as the pending set equals the captured snapshot and is not empty.
- R5: When all unmasked requests are gone, the wire is high in the period after the frame ends, or in the period after the drop if the wire was being held.
- R6: If the pending set changes to another non-empty set while the wire is held, the wire is high for exactly one period and then a new marker and frame carrying the new set follow.
- R7: Slot values come from the snapshot taken at the marker; input changes during a frame do not alter its slots, and a set that differs from the snapshot at frame end causes one high period and a new frame.
- R8: While reset is asserted the wire is high, whatever the request inputs.
- R9: Between the wire going high and the next start marker there is at least one high period.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dreq | input | NUM_CH | Legacy DMA request lines, active high, one per channel |
| req_n | output | 1 | Serial request wire to the arbiter, active low |

## Verification
A corrupted sequencer state or slot counter shows on the wire within one clock as a misplaced marker, a shifted slot or a missing high gap, so each frame is compared bit by bit against levels worked out from the request pattern. A stale or wrongly loaded snapshot appears at the latest in the next frame's slots, or as a missing re-send at frame end. The directed cases change the inputs in the middle of a frame and during the hold phase to expose it.

// File: rtl/dreq_ser_pkg.sv
package dreq_ser_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_START = 2'd1,
      ST_DATA  = 2'd2,
      ST_HOLD  = 2'd3
   } ser_state_e;

endpackage

// File: rtl/dreq_ser_capture.sv
module dreq_ser_capture #(
   parameter int unsigned          NUM_CH    = 8,
   parameter logic [NUM_CH-1:0]    FORCE_LOW = NUM_CH'(8'h10)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] dreq,
   input  logic              load,
   output logic [NUM_CH-1:0] eff_req,
   output logic [NUM_CH-1:0] shadow,
   output logic              any_req,
   output logic              set_changed
);

   logic [NUM_CH-1:0] shadow_q;

   // masked channels never count as pending
   assign eff_req     = dreq & ~FORCE_LOW;
   assign any_req     = |eff_req;
   assign set_changed = (eff_req != shadow_q);
   assign shadow      = shadow_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    shadow_q <= '0;
      else if (load) shadow_q <= eff_req;
   end

endmodule

// File: rtl/dreq_ser_seq.sv
module dreq_ser_seq
   import dreq_ser_pkg::*;
#(
   parameter int unsigned NUM_CH = 8,
   localparam int unsigned SW    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          any_req,
   input  logic          set_changed,
   output ser_state_e    state,
   output logic [SW-1:0] slot,
   output logic          load
);

   localparam logic [SW-1:0] LAST = SW'(NUM_CH - 1);

   ser_state_e    state_q, state_d;
   logic [SW-1:0] slot_q, slot_d;

   assign load  = (state_q == ST_IDLE) && any_req;
   assign state = state_q;
   assign slot  = slot_q;

   always_comb begin
      state_d = state_q;
      slot_d  = slot_q;
      unique case (state_q)
         ST_IDLE:  if (any_req) state_d = ST_START;
         ST_START: begin
            state_d = ST_DATA;
            slot_d  = '0;
         end
         ST_DATA: begin
            if (slot_q == LAST) begin
               state_d = (!any_req || set_changed) ? ST_IDLE : ST_HOLD;
            end else begin
               slot_d = slot_q + SW'(1);
            end
         end
         ST_HOLD:  if (!any_req || set_changed) state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         slot_q  <= '0;
      end else begin
         state_q <= state_d;
         slot_q  <= slot_d;
      end
   end

endmodule

// File: rtl/dreq_ser_slot_mux.sv
module dreq_ser_slot_mux
   import dreq_ser_pkg::*;
#(
   parameter int unsigned          NUM_CH    = 8,
   parameter logic [NUM_CH-1:0]    FORCE_LOW = NUM_CH'(8'h10),
   localparam int unsigned         SW        = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  ser_state_e        state,
   input  logic [SW-1:0]     slot,
   input  logic [NUM_CH-1:0] shadow,
   output logic              req_n
);

   logic [NUM_CH-1:0] slot_lvl;

   for (genvar g = 0; g < NUM_CH; g++) begin : g_lvl
      if (FORCE_LOW[g]) begin : g_forced
         assign slot_lvl[g] = 1'b0;
      end else begin : g_live
         assign slot_lvl[g] = ~shadow[g];
      end
   end

   always_comb begin
      unique case (state)
         ST_IDLE:  req_n = 1'b1;
         ST_DATA:  req_n = slot_lvl[slot];
         default:  req_n = 1'b0;
      endcase
   end

endmodule

// File: rtl/dreq_serial_enc.sv
module dreq_serial_enc
   import dreq_ser_pkg::*;
#(
   parameter int unsigned          NUM_CH    = 8,
   parameter logic [NUM_CH-1:0]    FORCE_LOW = NUM_CH'(8'h10)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] dreq,
   output logic              req_n
);

   localparam int unsigned SW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

   if (NUM_CH < 2) begin : g_bad_width
      $error("dreq_serial_enc: NUM_CH must be at least 2");
   end
   if (FORCE_LOW == {NUM_CH{1'b1}}) begin : g_bad_mask
      $error("dreq_serial_enc: every channel masked");
   end

   logic [NUM_CH-1:0] eff_req;
   logic [NUM_CH-1:0] shadow;
   logic              any_req;
   logic              set_changed;
   logic              load;
   ser_state_e        state;
   logic [SW-1:0]     slot;

   dreq_ser_capture #(.NUM_CH(NUM_CH), .FORCE_LOW(FORCE_LOW)) u_cap (
      .clk(clk), .rst_n(rst_n), .dreq(dreq), .load(load),
      .eff_req(eff_req), .shadow(shadow), .any_req(any_req),
      .set_changed(set_changed)
   );

   dreq_ser_seq #(.NUM_CH(NUM_CH)) u_seq (
      .clk(clk), .rst_n(rst_n), .any_req(any_req),
      .set_changed(set_changed), .state(state), .slot(slot), .load(load)
   );

   dreq_ser_slot_mux #(.NUM_CH(NUM_CH), .FORCE_LOW(FORCE_LOW)) u_mux (
      .state(state), .slot(slot), .shadow(shadow), .req_n(req_n)
   );

endmodule

// File: rtl/dreq_ser_chk.sv
module dreq_ser_chk
   import dreq_ser_pkg::*;
#(
   parameter int unsigned          NUM_CH    = 8,
   parameter logic [NUM_CH-1:0]    FORCE_LOW = NUM_CH'(8'h10),
   localparam int unsigned         SW        = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_n,
   input ser_state_e        state,
   input logic [SW-1:0]     slot,
   input logic [NUM_CH-1:0] eff_req,
   input logic [NUM_CH-1:0] shadow
);

   localparam logic [SW-1:0] LAST = SW'(NUM_CH - 1);

   // R8
   reset_high_chk: assert property (@(posedge clk) !rst_n |-> req_n);

   // R1
   marker_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_START |=> (state == ST_DATA && slot == '0));

   // R9
   idle_before_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_START |-> $past(req_n));

   // R2
   slot_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DATA && slot != LAST) |=> (state == ST_DATA && slot == $past(slot) + SW'(1)));

   // R3
   masked_slot_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DATA && FORCE_LOW[slot]) |-> !req_n);

   // R7
   snapshot_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_DATA |-> $stable(shadow));

   // R5
   release_on_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state) == ST_HOLD && $past(eff_req) == '0) |-> req_n);

endmodule

bind dreq_serial_enc dreq_ser_chk #(.NUM_CH(NUM_CH), .FORCE_LOW(FORCE_LOW)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_n(req_n), .state(state), .slot(slot),
   .eff_req(eff_req), .shadow(shadow)
);

// File: tb/test_dreq_serial_enc.sv
`timescale 1ns/1ps
module test_dreq_serial_enc;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] dreq = '0;
   logic       req_n;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   always #4 clk = ~clk;

   dreq_serial_enc i_dreq_serial_enc (.clk(clk), .rst_n(rst_n), .dreq(dreq), .req_n(req_n));

   // {request pattern, expected slot levels (bit i = slot of channel i)}
   localparam logic [15:0] VEC [8] = '{
      {8'h01, 8'hEE}, {8'h80, 8'h6F}, {8'hFF, 8'h00}, {8'hA5, 8'h4A},
      {8'h3C, 8'hC3}, {8'h5A, 8'hA5}, {8'hFE, 8'h01}, {8'h12, 8'hED}
   };

   task automatic step();
      @(posedge clk);
      #4;
   endtask

   task automatic chk(input logic exp, input string req);
      n_chk++;
      if (req_n !== exp) begin
         n_fail++;
         $display("FAIL %s t=%0t req_n=%b expected=%b", req, $time, req_n, exp);
      end
   endtask

   // marker and eight slots; sampled after each edge
   task automatic frame(input logic [7:0] lvl, input string req);
      step(); chk(1'b0, "R1");
      for (int i = 0; i < 8; i++) begin
         step(); chk(lvl[i], req);
      end
   endtask

   initial begin
      dreq = 8'hFF;
      repeat (3) begin
         #3; chk(1'b1, "R8");
         @(posedge clk);
      end
      #4; chk(1'b1, "R8");
      dreq = '0;
      rst_n = 1'b1;
      step(); chk(1'b1, "R8");

      // vector walk
      for (int v = 0; v < 8; v++) begin
         dreq = VEC[v][15:8];
         frame(VEC[v][7:0], "R2");
         step(); chk(1'b0, "R4");
         step(); chk(1'b0, "R4");
         dreq = '0;
         step(); chk(1'b1, "R5");
         step(); chk(1'b1, "R9");
      end

      // R3: masked channel alone never starts a frame
      dreq = 8'h10;
      for (int i = 0; i < 12; i++) begin
         step(); chk(1'b1, "R3");
      end
      dreq = '0;
      step();

      // R3: masked channel toggling during hold causes no re-send
      dreq = 8'h01;
      frame(8'hEE, "R3");
      step(); chk(1'b0, "R4");
      dreq = 8'h11;
      step(); chk(1'b0, "R3");
      step(); chk(1'b0, "R3");
      dreq = '0;
      step(); chk(1'b1, "R5");
      step();

      // R6: change of set during hold
      dreq = 8'h01;
      frame(8'hEE, "R2");
      step(); chk(1'b0, "R4");
      dreq = 8'h03;
      step(); chk(1'b1, "R6");
      frame(8'hEC, "R6");
      step(); chk(1'b0, "R6");
      dreq = '0;
      step(); chk(1'b1, "R5");
      step();

      // R7: inputs change inside a frame
      dreq = 8'h01;
      step(); chk(1'b0, "R1");
      dreq = 8'h02;
      for (int i = 0; i < 8; i++) begin
         step(); chk(8'hEE >> i, "R7");
      end
      step(); chk(1'b1, "R7");
      frame(8'hED, "R7");
      step(); chk(1'b0, "R7");
      dreq = '0;
      step(); chk(1'b1, "R5");
      step();

      // R5: drop inside a frame releases after the last slot
      dreq = 8'h80;
      step(); chk(1'b0, "R1");
      dreq = '0;
      for (int i = 0; i < 8; i++) begin
         step(); chk(8'h6F >> i, "R7");
      end
      step(); chk(1'b1, "R5");
      step(); chk(1'b1, "R5");

      // R9: request back right after release
      dreq = 8'h01;
      frame(8'hEE, "R2");
      step(); chk(1'b0, "R4");
      dreq = '0;
      step(); chk(1'b1, "R5");
      dreq = 8'h01;
      step(); chk(1'b0, "R9");
      dreq = '0;
      repeat (10) step();
      chk(1'b1, "R5");

      done = 1;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 20000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run hung, done=0 expected=1");
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule